// File: doc/BRIEF.md
# Programmable interrupt line router

The block steers 128 peripheral interrupt request lines onto 24 lines that feed a downstream interrupt controller. Every input owns one 32-bit route word that names a destination output and carries an enable flag. Each output is the OR of every enabled input currently pointed at it. There is no storage in the signal path, so an output rises and falls with the levels of its sources, and the downstream controller decides whether a line is treated as level or edge.

Software programs the routes over a small memory-mapped register bus with separate read and write strobes. Four read-only words return the instantaneous level of all 128 inputs, so software can see which source is active behind a shared output. Route words clear on reset, so nothing reaches the controller until software enables a route.

Top module: `irq_line_router`

## Requirements
- R1: After reset every route word reads 0x00000000, every output is 0 and the read data bus is 0.
- R2: A write to byte offset 4*i (i from 0 to 127) with bit 31 set and destination d (0 to 23) in bits 4:0 makes output d follow input i from the clock edge that samples the write strobe.
- R3: When several enabled routes point at one output, that output is 1 whenever at least one of their inputs is 1.
- R4: A route word with bit 31 clear, including the all-zero word, connects its input to no output.
- R5: An enabled route whose destination field holds 24 to 31 connects its input to no output.
- R6: A route word reads back with bit 31 and bits 4:0 as last written and bits 30:5 as zero; read data appears on the clock after the read strobe.
- R7: A read of byte offset 0x200 + 4*k (k from 0 to 3) returns the level of input 32*k + b in bit b, sampled at the edge that samples the read strobe.
- R8: Writes to the status words or to any offset from 0x210 upward change no route; reads of offsets from 0x210 upward return zero.
- R9: Outputs follow inputs with no latching: an output falls as soon as all its enabled sources are 0.
- R10: The read data bus holds its last value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 128 | Peripheral interrupt request levels |
| irq_out | output | 24 | Routed interrupt lines to the downstream controller |
| bus_addr | input | 10 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
The embedded properties check every cycle that a route write lands in the addressed entry, that writes elsewhere leave the route table untouched, that outputs are quiet when no input is high or no route is enabled, that reserved bits read as zero, that the first status word mirrors the inputs and that read data holds between reads. Whether a given input actually drives the right output, how several sources merge on one output, the handling of destinations 24 to 31 and the exact readback values are shown by the bench, whose behavioural model predicts every output and every read word on each clock across directed scenarios and a long mixed stream of writes, reads and input changes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int REG_W  = 32;
    localparam int EN_BIT = 31;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_ROUTE = 2'd1,
        SEL_STAT  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_router_pkg::*;
#(
    parameter int N_IN   = 128,
    parameter int N_STAT = 4,
    parameter int ADDR_W = 10,
    parameter int IN_W   = 7,
    parameter int ST_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IN_W-1:0]   route_idx,
    output logic [ST_W-1:0]   stat_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        sel       = SEL_NONE;
        route_idx = word[IN_W-1:0];
        stat_idx  = '0;
        if (int'(word) < N_IN) begin
            sel = SEL_ROUTE;
        end else if (int'(word) < N_IN + N_STAT) begin
            sel      = SEL_STAT;
            stat_idx = ST_W'(int'(word) - N_IN);
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter int N_IN  = 128,
    parameter int IN_W  = 7,
    parameter int OUT_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IN_W-1:0]            wr_idx,
    input  logic [REG_W-1:0]           wr_data,
    output logic [N_IN-1:0]            en_q,
    output logic [N_IN-1:0][OUT_W-1:0] dst_q
);
    typedef struct packed {
        logic [N_IN-1:0]            en;
        logic [N_IN-1:0][OUT_W-1:0] dst;
    } route_st_t;

    route_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en[wr_idx]  = wr_data[EN_BIT];
            st_d.dst[wr_idx] = wr_data[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q  = st_q.en;
    assign dst_q = st_q.dst;

    // R2: the addressed entry takes the written enable and destination
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q[$past(wr_idx)] == $past(wr_data[EN_BIT])) &&
                  (dst_q[$past(wr_idx)] == $past(wr_data[OUT_W-1:0])));
endmodule

// File: rtl/irq_or_net.sv
module irq_or_net #(
    parameter int N_IN  = 128,
    parameter int N_OUT = 24,
    parameter int OUT_W = 5
) (
    input  logic [N_IN-1:0]            irq_in,
    input  logic [N_IN-1:0]            en,
    input  logic [N_IN-1:0][OUT_W-1:0] dst,
    output logic [N_OUT-1:0]           irq_out
);
    logic [N_IN-1:0] live;
    assign live = irq_in & en;

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_IN-1:0] hit;
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                hit[i] = live[i] && (dst[i] == OUT_W'(j));
            end
        end
        assign irq_out[j] = |hit;
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_router_pkg::*;
#(
    parameter int N_IN   = 128,
    parameter int N_STAT = 4,
    parameter int IN_W   = 7,
    parameter int ST_W   = 2,
    parameter int OUT_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  reg_sel_e                   sel,
    input  logic [IN_W-1:0]            route_idx,
    input  logic [ST_W-1:0]            stat_idx,
    input  logic [N_IN-1:0]            en,
    input  logic [N_IN-1:0][OUT_W-1:0] dst,
    input  logic [N_IN-1:0]            irq_in,
    output logic [REG_W-1:0]           rdata
);
    localparam int STAT_BITS = N_STAT * REG_W;

    logic [STAT_BITS-1:0] stat_vec;
    logic [REG_W-1:0]     rdata_d, rdata_q;

    assign stat_vec = STAT_BITS'(irq_in);

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            rdata_d = '0;
            unique case (sel)
                SEL_ROUTE: begin
                    rdata_d[EN_BIT]    = en[route_idx];
                    rdata_d[OUT_W-1:0] = dst[route_idx];
                end
                SEL_STAT: rdata_d = stat_vec[stat_idx*REG_W +: REG_W];
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R6: reserved field of a route word always reads zero
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_ROUTE) |=> rdata[EN_BIT-1:OUT_W] == '0);

    // R7: first status word mirrors the low 32 inputs at the strobe edge
    assert_stat_raw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_STAT && stat_idx == '0) |=> rdata == $past(irq_in[REG_W-1:0]));

    // R10: read data holds between strobes
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
    import irq_router_pkg::*;
#(
    parameter int N_IN   = 128,
    parameter int N_OUT  = 24,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   irq_in,
    output logic [N_OUT-1:0]  irq_out,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata
);
    localparam int N_STAT = (N_IN + REG_W - 1) / REG_W;
    localparam int IN_W   = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int ST_W   = (N_STAT > 1) ? $clog2(N_STAT) : 1;
    localparam int OUT_W  = 5;

    reg_sel_e                   sel;
    logic [IN_W-1:0]            route_idx;
    logic [ST_W-1:0]            stat_idx;
    logic [N_IN-1:0]            route_en;
    logic [N_IN-1:0][OUT_W-1:0] route_dst;
    logic                       wr_route;

    irq_addr_decode #(
        .N_IN(N_IN), .N_STAT(N_STAT), .ADDR_W(ADDR_W), .IN_W(IN_W), .ST_W(ST_W)
    ) u_dec (
        .addr(bus_addr), .sel(sel), .route_idx(route_idx), .stat_idx(stat_idx)
    );

    assign wr_route = bus_wr && (sel == SEL_ROUTE);

    irq_route_regs #(
        .N_IN(N_IN), .IN_W(IN_W), .OUT_W(OUT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_route), .wr_idx(route_idx),
        .wr_data(bus_wdata), .en_q(route_en), .dst_q(route_dst)
    );

    irq_or_net #(
        .N_IN(N_IN), .N_OUT(N_OUT), .OUT_W(OUT_W)
    ) u_net (
        .irq_in(irq_in), .en(route_en), .dst(route_dst), .irq_out(irq_out)
    );

    irq_read_port #(
        .N_IN(N_IN), .N_STAT(N_STAT), .IN_W(IN_W), .ST_W(ST_W), .OUT_W(OUT_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel), .route_idx(route_idx),
        .stat_idx(stat_idx), .en(route_en), .dst(route_dst), .irq_in(irq_in),
        .rdata(bus_rdata)
    );

    // R8: accesses outside the route words leave the route table alone
    assert_stray_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel != SEL_ROUTE) |=> $stable(route_en) && $stable(route_dst));

    // R9: no input high means no output high
    assert_quiet_inputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |-> (irq_out == '0));

    // R4: with every route disabled no output is driven
    assert_all_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (route_en == '0) |-> (irq_out == '0));
endmodule

// File: tb/irq_line_router_bench.sv
module irq_line_router_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq_in = '0;
    logic [23:0]  irq_out;
    logic [9:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;

    int total = 0;
    int bad   = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    // behavioural model
    bit [127:0] m_en;
    int         m_dst [128];
    logic [31:0] m_rdata = '0;

    always #5 clk = ~clk;

    irq_line_router u_irq_line_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    function automatic logic [23:0] model_out(input logic [127:0] lv);
        logic [23:0] o = '0;
        for (int i = 0; i < 128; i++)
            if (m_en[i] && lv[i] && m_dst[i] < 24) o[m_dst[i]] = 1'b1;
        return o;
    endfunction

    always @(posedge clk) begin
        int w;
        w = int'(bus_addr) >> 2;
        if (!rst_n) begin
            m_en = '0;
            for (int i = 0; i < 128; i++) m_dst[i] = 0;
            m_rdata = '0;
        end else begin
            if (bus_rd) begin
                if (w < 128) begin
                    m_rdata = '0;
                    m_rdata[31] = m_en[w];
                    m_rdata[4:0] = m_dst[w][4:0];
                end else if (w < 132) begin
                    m_rdata = irq_in[(w-128)*32 +: 32];
                end else begin
                    m_rdata = '0;
                end
            end
            if (bus_wr && w < 128) begin
                m_en[w] = bus_wdata[31];
                m_dst[w] = int'(bus_wdata[4:0]);
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (checking) begin
            check("R3 per-cycle output", 128'(irq_out), 128'(model_out(irq_in)));
            check("R6 per-cycle rdata", 128'(bus_rdata), 128'(m_rdata));
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [9:0] a, output logic [31:0] d);
        step();
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_in(input logic [127:0] v);
        irq_in = v;
        #1;
    endtask

    function automatic logic [127:0] bit_at(input int n);
        logic [127:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) step();
        check("R1 output in reset", 128'(irq_out), 128'h0);
        rst_n = 1'b1;
        step();
        checking = 1'b1;
        check("R1 rdata after reset", 128'(bus_rdata), 128'h0);
        set_in({128{1'b1}});
        check("R1 outputs with no routes", 128'(irq_out), 128'h0);
        rd_reg(10'h014, d);
        check("R1 route word 5 after reset", 128'(d), 128'h0);
        rd_reg(10'h1FC, d);
        check("R1 route word 127 after reset", 128'(d), 128'h0);
        set_in('0);

        // R2: input 120 to output 7
        wr_reg(10'h1E0, 32'h8000_0007);
        set_in(bit_at(120));
        check("R2 input 120 on output 7", 128'(irq_out), 128'(24'h00_0080));
        rd_reg(10'h1E0, d);
        check("R6 readback route 120", 128'(d), 128'h8000_0007);

        // R3: inputs 3 and 64 share output 23
        wr_reg(10'h00C, 32'h8000_0017);
        wr_reg(10'h100, 32'h8000_0017);
        set_in(bit_at(3));
        check("R3 input 3 alone on output 23", 128'(irq_out), 128'(24'h80_0000));
        set_in(bit_at(3) | bit_at(64) | bit_at(120));
        check("R3 both sources plus 120", 128'(irq_out), 128'(24'h80_0080));
        set_in(bit_at(64));
        check("R9 drop input 3 keeps 64", 128'(irq_out), 128'(24'h80_0000));
        set_in('0);
        check("R9 all sources low", 128'(irq_out), 128'h0);

        // R4: disabling
        wr_reg(10'h1E0, 32'h0000_0000);
        set_in(bit_at(120));
        check("R4 zero word disables 120", 128'(irq_out), 128'h0);
        wr_reg(10'h1E0, 32'h0000_0007);
        check("R4 enable clear disables 120", 128'(irq_out), 128'h0);
        rd_reg(10'h1E0, d);
        check("R6 readback disabled route", 128'(d), 128'h0000_0007);
        set_in('0);

        // R5: out-of-range destinations
        wr_reg(10'h028, 32'h8000_0018);
        set_in(bit_at(10));
        check("R5 destination 24 drives nothing", 128'(irq_out), 128'h0);
        wr_reg(10'h028, 32'h8000_001F);
        check("R5 destination 31 drives nothing", 128'(irq_out), 128'h0);
        rd_reg(10'h028, d);
        check("R6 readback destination 31", 128'(d), 128'h8000_001F);
        set_in('0);

        // R6: reserved bits dropped
        wr_reg(10'h004, 32'hFFFF_FFE2);
        rd_reg(10'h004, d);
        check("R6 reserved bits read zero", 128'(d), 128'h8000_0002);
        set_in(bit_at(1));
        check("R2 input 1 on output 2", 128'(irq_out), 128'(24'h00_0004));

        // R7: raw status
        set_in(128'hDEAD_BEEF_0123_4567_89AB_CDEF_F0E1_D2C3);
        rd_reg(10'h200, d);
        check("R7 status word 0", 128'(d), 128'hF0E1_D2C3);
        rd_reg(10'h204, d);
        check("R7 status word 1", 128'(d), 128'h89AB_CDEF);
        rd_reg(10'h208, d);
        check("R7 status word 2", 128'(d), 128'h0123_4567);
        rd_reg(10'h20C, d);
        check("R7 status word 3", 128'(d), 128'hDEAD_BEEF);

        // R10: hold between reads
        repeat (4) step();
        check("R10 rdata held", 128'(bus_rdata), 128'hDEAD_BEEF);

        // R8: stray writes
        wr_reg(10'h204, 32'h8000_0003);
        wr_reg(10'h3FC, 32'hFFFF_FFFF);
        rd_reg(10'h004, d);
        check("R8 route 1 unchanged", 128'(d), 128'h8000_0002);
        rd_reg(10'h204, d);
        check("R8 status still raw", 128'(d), 128'h89AB_CDEF);
        rd_reg(10'h3F0, d);
        check("R8 unmapped reads zero", 128'(d), 128'h0);
        rd_reg(10'h210, d);
        check("R8 first unmapped reads zero", 128'(d), 128'h0);

        // mixed stream checked by the per-cycle model
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            set_in({$urandom, $urandom, $urandom, $urandom});
            if (r[1:0] != 2'd0) begin
                wr_reg({1'b0, r[8:2], 2'b00}, {r[9], 26'h0, r[14:10]} | (r[15] ? 32'h3FF_FFE0 : 32'h0));
            end else begin
                rd_reg({r[9], r[8:2] & (r[9] ? 7'h03 : 7'h7F), 2'b00}, d);
            end
            step();
        end

        done = 1'b1;
        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule